// File: doc/BRIEF.md
# Trap Entry Controller

This block performs the single-cycle trap-entry step of a small hart that has user, supervisor and machine privilege levels. When the pipeline raises a trap request, it gives the cause code, whether the trap is an interrupt, the PC of the trapping instruction, the current privilege and any faulting address. In response, the block picks the privilege level that handles the trap and produces the handler PC. It also updates the cause, exception-PC and trap-value registers of that level, stacks the interrupt-enable state, and records the new privilege.

The block holds the two trap-vector registers, the exception and interrupt delegation masks, and the two global interrupt-enable bits. A small write port loads them. The port refuses vector writes that carry a reserved mode. A trap request has priority over a write in the same cycle. A vector register in vectored mode moves interrupt handlers to `base + 4*cause`. Exceptions always land on the base.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, `priv_o` is 3 (machine). All vector, delegation, cause, EPC and trap-value outputs, `next_pc_o` and every status bit are zero.
- R2: A write to a vector register stores the whole word when `csr_wdata_i[1:0]` is 0 (direct) or 1 (vectored). When `csr_wdata_i[1:0]` is 2 or 3, the write is dropped and the register keeps its old value. `csr_sel_i` selects the target: 0 for the machine vector, 1 for the supervisor vector, 2 for the exception delegation mask, 3 for the interrupt delegation mask, and 4 for status. A status write sets the machine enable from `csr_wdata_i[3]` and the supervisor enable from `csr_wdata_i[1]`.
- R3: For an exception (`trap_async_i`=0), `next_pc_o` is the target vector with its two low bits cleared, whatever the vector's mode.
- R4: For an interrupt taken through a vector register in mode 1, `next_pc_o` is the cleared base plus 4 times the cause. In mode 0 it is the base.
- R5: The trap goes to supervisor (`priv_o`=1) only when all three hold: `priv_i` is 0 or 1, the cause is below XLEN, and the cause's bit is set in the delegation mask. In every other case it goes to machine (`priv_o`=3).
- R6: Interrupts are delegated by the interrupt mask. Exceptions are delegated by the exception mask.
- R7: The target cause register receives the final cause code, zero-extended, with bit XLEN-1 equal to `trap_async_i`.
- R8: An exception with cause 8 is rewritten before delegation according to `priv_i`: 8 when `priv_i` is 0, 9 when it is 1, 10 when it is 2, and 11 when it is 3.
- R9: The target trap-value register receives `fault_addr_i` only for exception causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. For every other trap it receives zero.
- R10: On a machine entry, the machine previous-enable bit takes the old machine enable, the machine previous-privilege field takes `priv_i`, and the machine enable clears.
- R11: On a supervisor entry, the supervisor previous-enable bit takes the old supervisor enable, `spp_o` takes `priv_i[0]` (0 from user, 1 from supervisor), and the supervisor enable clears.
- R12: The target EPC register captures `trap_pc_i`. All of these updates appear after the clock edge at which `trap_req_i` is high.
- R13: A register write in the same cycle as `trap_req_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_req_i | input | 1 | Take a trap this cycle |
| trap_async_i | input | 1 | 1 for interrupt, 0 for exception |
| trap_cause_i | input | CAUSE_W | Raw cause code |
| trap_pc_i | input | XLEN | PC of trapping instruction |
| priv_i | input | 2 | Current privilege (0 U, 1 S, 3 M) |
| fault_addr_i | input | XLEN | Faulting address |
| csr_we_i | input | 1 | Register write strobe |
| csr_sel_i | input | 3 | Write target select |
| csr_wdata_i | input | XLEN | Write data |
| next_pc_o | output | XLEN | Handler PC of last trap |
| priv_o | output | 2 | Privilege after last trap |
| mtvec_o | output | XLEN | Machine vector |
| stvec_o | output | XLEN | Supervisor vector |
| medeleg_o | output | XLEN | Exception delegation mask |
| mideleg_o | output | XLEN | Interrupt delegation mask |
| mcause_o | output | XLEN | Machine cause |
| scause_o | output | XLEN | Supervisor cause |
| mepc_o | output | XLEN | Machine EPC |
| sepc_o | output | XLEN | Supervisor EPC |
| mtval_o | output | XLEN | Machine trap value |
| stval_o | output | XLEN | Supervisor trap value |
| mie_o | output | 1 | Machine interrupt enable |
| mpie_o | output | 1 | Machine previous enable |
| mpp_o | output | 2 | Machine previous privilege |
| sie_o | output | 1 | Supervisor interrupt enable |
| spie_o | output | 1 | Supervisor previous enable |
| spp_o | output | 1 | Supervisor previous privilege |

## Verification
Each trap is tried as both an exception and an interrupt against a vectored base, which separates the offset path from the base-only path. Some causes carry an address and some do not, which separates the two trap-value choices. The same cause number is sent through both delegation masks from user, supervisor and machine privilege, so a swapped mask or a missing privilege check routes the trap to the wrong level. Several tests cover corner cases: environment calls from every level, including one that is delegated only after its rewrite; a cause above XLEN with a mask of all ones; and a write issued in the same cycle as a trap.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [1:0] {PRIV_U = 2'd0, PRIV_S = 2'd1, PRIV_H = 2'd2, PRIV_M = 2'd3} priv_e;

  typedef enum logic [2:0] {
    SEL_MTVEC = 3'd0, SEL_STVEC = 3'd1, SEL_EDLG = 3'd2, SEL_IDLG = 3'd3, SEL_STAT = 3'd4
  } csr_sel_e;

  localparam int unsigned ECALL_U = 8;
  localparam int unsigned ECALL_S = 9;
  localparam int unsigned ECALL_H = 10;
  localparam int unsigned ECALL_M = 11;

  // exceptions that report a faulting address
  function automatic logic carries_addr(input int unsigned c);
    case (c)
      0, 1, 4, 5, 6, 7, 12, 13, 15: return 1'b1;
      default:                     return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/tvec_reg.sv
module tvec_reg #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] q_o
);
  // reserved modes (2,3) are dropped
  logic accept;
  assign accept = we_i && !wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (accept) q_o <= wdata_i;
  end
endmodule

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [1:0]         priv_i,
  input  logic [XLEN-1:0]    edlg_i,
  input  logic [XLEN-1:0]    idlg_i,
  input  logic [XLEN-1:0]    fault_addr_i,
  output logic               to_s_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [XLEN-1:0]    cause_word_o,
  output logic [XLEN-1:0]    tval_o
);
  logic [XLEN-1:0] mask;
  logic            dlg_bit;
  logic            low_priv;

  always_comb begin
    cause_o = cause_i;
    if (!async_i && (32'(cause_i) == ECALL_U)) begin
      case (priv_i)
        PRIV_U:  cause_o = CAUSE_W'(ECALL_U);
        PRIV_S:  cause_o = CAUSE_W'(ECALL_S);
        PRIV_H:  cause_o = CAUSE_W'(ECALL_H);
        default: cause_o = CAUSE_W'(ECALL_M);
      endcase
    end
  end

  assign mask = async_i ? idlg_i : edlg_i;

  // causes at or above XLEN never match a mask bit
  always_comb begin
    dlg_bit = 1'b0;
    for (int i = 0; i < int'(XLEN); i++)
      if (32'(cause_o) == 32'(i)) dlg_bit = mask[i];
  end

  assign low_priv = (priv_i == PRIV_U) || (priv_i == PRIV_S);
  assign to_s_o   = low_priv && dlg_bit;

  always_comb begin
    cause_word_o                = '0;
    cause_word_o[CAUSE_W-1:0]   = cause_o;
    cause_word_o[XLEN-1]        = async_i;
  end

  assign tval_o = (!async_i && carries_addr(32'(cause_o))) ? fault_addr_i : '0;
endmodule

// File: rtl/trap_vector_calc.sv
module trap_vector_calc #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic [XLEN-1:0]    tvec_i,
  input  logic               async_i,
  input  logic [CAUSE_W-1:0] cause_i,
  output logic [XLEN-1:0]    pc_o
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  assign base = {tvec_i[XLEN-1:2], 2'b00};
  assign offs = {{(XLEN-CAUSE_W){1'b0}}, cause_i} << 2;
  assign pc_o = (async_i && (tvec_i[1:0] == 2'b01)) ? base + offs : base;
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trap_req_i,
  input  logic               trap_async_i,
  input  logic [CAUSE_W-1:0] trap_cause_i,
  input  logic [XLEN-1:0]    trap_pc_i,
  input  logic [1:0]         priv_i,
  input  logic [XLEN-1:0]    fault_addr_i,
  input  logic               csr_we_i,
  input  logic [2:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic [1:0]         priv_o,
  output logic [XLEN-1:0]    mtvec_o,
  output logic [XLEN-1:0]    stvec_o,
  output logic [XLEN-1:0]    medeleg_o,
  output logic [XLEN-1:0]    mideleg_o,
  output logic [XLEN-1:0]    mcause_o,
  output logic [XLEN-1:0]    scause_o,
  output logic [XLEN-1:0]    mepc_o,
  output logic [XLEN-1:0]    sepc_o,
  output logic [XLEN-1:0]    mtval_o,
  output logic [XLEN-1:0]    stval_o,
  output logic               mie_o,
  output logic               mpie_o,
  output logic [1:0]         mpp_o,
  output logic               sie_o,
  output logic               spie_o,
  output logic               spp_o
);
  localparam int unsigned NVEC = 2;

  logic               wr_ok;
  logic [XLEN-1:0]    tvec_q [NVEC];
  logic               to_s;
  logic [CAUSE_W-1:0] cause_fix;
  logic [XLEN-1:0]    cause_word;
  logic [XLEN-1:0]    tval;
  logic [XLEN-1:0]    tgt_tvec;
  logic [XLEN-1:0]    hpc;

  // trap wins over a register write in the same cycle
  assign wr_ok = csr_we_i && !trap_req_i;

  for (genvar g = 0; g < NVEC; g++) begin : g_tvec
    tvec_reg #(.XLEN(XLEN)) u_tvec (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_ok && (csr_sel_i == 3'(g))),
      .wdata_i (csr_wdata_i),
      .q_o     (tvec_q[g])
    );
  end

  assign mtvec_o = tvec_q[0];
  assign stvec_o = tvec_q[1];

  trap_route #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_route (
    .async_i      (trap_async_i),
    .cause_i      (trap_cause_i),
    .priv_i       (priv_i),
    .edlg_i       (medeleg_o),
    .idlg_i       (mideleg_o),
    .fault_addr_i (fault_addr_i),
    .to_s_o       (to_s),
    .cause_o      (cause_fix),
    .cause_word_o (cause_word),
    .tval_o       (tval)
  );

  assign tgt_tvec = to_s ? stvec_o : mtvec_o;

  trap_vector_calc #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_vec (
    .tvec_i  (tgt_tvec),
    .async_i (trap_async_i),
    .cause_i (cause_fix),
    .pc_o    (hpc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      priv_o    <= PRIV_M;
      medeleg_o <= '0;
      mideleg_o <= '0;
      mcause_o  <= '0;
      scause_o  <= '0;
      mepc_o    <= '0;
      sepc_o    <= '0;
      mtval_o   <= '0;
      stval_o   <= '0;
      mie_o     <= 1'b0;
      mpie_o    <= 1'b0;
      mpp_o     <= 2'b00;
      sie_o     <= 1'b0;
      spie_o    <= 1'b0;
      spp_o     <= 1'b0;
    end else if (trap_req_i) begin
      next_pc_o <= hpc;
      if (to_s) begin
        priv_o   <= PRIV_S;
        scause_o <= cause_word;
        sepc_o   <= trap_pc_i;
        stval_o  <= tval;
        spie_o   <= sie_o;
        spp_o    <= priv_i[0];
        sie_o    <= 1'b0;
      end else begin
        priv_o   <= PRIV_M;
        mcause_o <= cause_word;
        mepc_o   <= trap_pc_i;
        mtval_o  <= tval;
        mpie_o   <= mie_o;
        mpp_o    <= priv_i;
        mie_o    <= 1'b0;
      end
    end else if (wr_ok) begin
      case (csr_sel_i)
        SEL_EDLG: medeleg_o <= csr_wdata_i;
        SEL_IDLG: mideleg_o <= csr_wdata_i;
        SEL_STAT: begin
          mie_o <= csr_wdata_i[3];
          sie_o <= csr_wdata_i[1];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trap_entry_ctrl_chk.sv
module trap_entry_ctrl_chk #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               trap_req_i,
  input logic               trap_async_i,
  input logic [CAUSE_W-1:0] trap_cause_i,
  input logic [XLEN-1:0]    trap_pc_i,
  input logic [1:0]         priv_i,
  input logic               csr_we_i,
  input logic [2:0]         csr_sel_i,
  input logic [XLEN-1:0]    csr_wdata_i,
  input logic [XLEN-1:0]    next_pc_o,
  input logic [1:0]         priv_o,
  input logic [XLEN-1:0]    mtvec_o,
  input logic [XLEN-1:0]    stvec_o,
  input logic [XLEN-1:0]    medeleg_o,
  input logic [XLEN-1:0]    mideleg_o,
  input logic [XLEN-1:0]    mcause_o,
  input logic [XLEN-1:0]    scause_o,
  input logic [XLEN-1:0]    mepc_o,
  input logic [XLEN-1:0]    sepc_o,
  input logic               mie_o,
  input logic               mpie_o,
  input logic [1:0]         mpp_o,
  input logic               sie_o,
  input logic               spie_o
);
  assert_no_reserved_mode_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mtvec_o[1] && !stvec_o[1]);

  assert_reserved_dropped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !trap_req_i && csr_sel_i == 3'd0 && csr_wdata_i[1]) |=> $stable(mtvec_o));

  assert_sync_to_base_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && !trap_async_i) |=> (next_pc_o[1:0] == 2'b00) &&
      ((priv_o == 2'd3) ? (next_pc_o[XLEN-1:2] == $past(mtvec_o[XLEN-1:2]))
                        : (next_pc_o[XLEN-1:2] == $past(stvec_o[XLEN-1:2]))));

  assert_m_stays_m_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_req_i && priv_i[1]) |=> (priv_o == 2'd3));

  assert_cause_msb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> ((priv_o == 2'd3) ? mcause_o[XLEN-1] : scause_o[XLEN-1]) == $past(trap_async_i));

  assert_status_stack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> (priv_o == 2'd3)
      ? (!mie_o && mpie_o == $past(mie_o) && mpp_o == $past(priv_i))
      : (!sie_o && spie_o == $past(sie_o)));

  assert_epc_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> ((priv_o == 2'd3) ? mepc_o : sepc_o) == $past(trap_pc_i));

  assert_trap_blocks_write_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_req_i |=> $stable(mtvec_o) && $stable(stvec_o) && $stable(medeleg_o) && $stable(mideleg_o));
endmodule

bind trap_entry_ctrl trap_entry_ctrl_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/trap_entry_ctrl_test.sv
module trap_entry_ctrl_test;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned CAUSE_W = 6;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               trap_req = 1'b0, trap_async = 1'b0;
  logic [CAUSE_W-1:0] trap_cause = '0;
  logic [XLEN-1:0]    trap_pc = '0, fault_addr = '0;
  logic [1:0]         priv = 2'd3;
  logic               csr_we = 1'b0;
  logic [2:0]         csr_sel = '0;
  logic [XLEN-1:0]    csr_wdata = '0;
  logic [XLEN-1:0]    next_pc, mtvec, stvec, medeleg, mideleg;
  logic [XLEN-1:0]    mcause, scause, mepc, sepc, mtval, stval;
  logic [1:0]         priv_q, mpp;
  logic               mie, mpie, sie, spie, spp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .trap_req_i(trap_req), .trap_async_i(trap_async),
    .trap_cause_i(trap_cause), .trap_pc_i(trap_pc), .priv_i(priv), .fault_addr_i(fault_addr),
    .csr_we_i(csr_we), .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata),
    .next_pc_o(next_pc), .priv_o(priv_q), .mtvec_o(mtvec), .stvec_o(stvec),
    .medeleg_o(medeleg), .mideleg_o(mideleg), .mcause_o(mcause), .scause_o(scause),
    .mepc_o(mepc), .sepc_o(sepc), .mtval_o(mtval), .stval_o(stval),
    .mie_o(mie), .mpie_o(mpie), .mpp_o(mpp), .sie_o(sie), .spie_o(spie), .spp_o(spp)
  );

  task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [XLEN-1:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_sel = sel; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic trap(input logic a, input int c, input logic [1:0] p,
                      input logic [XLEN-1:0] pc, input logic [XLEN-1:0] addr);
    @(negedge clk);
    trap_req = 1'b1; trap_async = a; trap_cause = CAUSE_W'(c); priv = p;
    trap_pc = pc; fault_addr = addr;
    @(negedge clk);
    trap_req = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 priv", 32'(priv_q), 32'd3);
    check("R1 mtvec", mtvec, 0);
    check("R1 stvec", stvec, 0);
    check("R1 medeleg", medeleg, 0);
    check("R1 mideleg", mideleg, 0);
    check("R1 mcause", mcause, 0);
    check("R1 next_pc", next_pc, 0);
    check("R1 status", {26'd0, mie, mpie, mpp, sie, spie, spp}, 0);
  endtask

  task automatic t_tvec_filter;
    wr(3'd0, 32'h0000_1001);
    check("R2 mtvec vectored stored", mtvec, 32'h0000_1001);
    wr(3'd0, 32'h0000_2002);
    check("R2 mtvec mode2 dropped", mtvec, 32'h0000_1001);
    wr(3'd0, 32'h0000_3003);
    check("R2 mtvec mode3 dropped", mtvec, 32'h0000_1001);
    wr(3'd1, 32'h0000_0800);
    check("R2 stvec direct stored", stvec, 32'h0000_0800);
  endtask

  task automatic t_machine_sync;
    wr(3'd4, 32'h8);
    check("R2 status write mie", 32'(mie), 1);
    trap(1'b0, 2, 2'd3, 32'h400, 32'hdead);
    check("R3 sync ignores vectored mode", next_pc, 32'h1000);
    check("R7 sync mcause", mcause, 32'd2);
    check("R12 mepc", mepc, 32'h400);
    check("R12 priv M", 32'(priv_q), 3);
    check("R9 tval zero for non-address cause", mtval, 0);
    check("R10 mie cleared", 32'(mie), 0);
    check("R10 mpie from mie", 32'(mpie), 1);
    check("R10 mpp", 32'(mpp), 3);
  endtask

  task automatic t_vectored;
    trap(1'b1, 7, 2'd3, 32'h500, 32'h0);
    check("R4 vectored offset", next_pc, 32'h101C);
    check("R7 interrupt mcause", mcause, 32'h8000_0007);
    check("R10 mpie from cleared mie", 32'(mpie), 0);
    wr(3'd0, 32'h0000_2000);
    trap(1'b1, 11, 2'd3, 32'h504, 32'h0);
    check("R4 direct interrupt to base", next_pc, 32'h2000);
  endtask

  task automatic t_delegate;
    wr(3'd2, 32'h0000_2000);
    wr(3'd3, 32'h0000_0020);
    wr(3'd4, 32'h2);
    trap(1'b0, 13, 2'd0, 32'h44, 32'hABC);
    check("R5 delegated to S", 32'(priv_q), 1);
    check("R5 S handler pc", next_pc, 32'h800);
    check("R7 scause", scause, 32'd13);
    check("R12 sepc", sepc, 32'h44);
    check("R9 stval address", stval, 32'hABC);
    check("R11 spie", 32'(spie), 1);
    check("R11 sie cleared", 32'(sie), 0);
    check("R11 spp from U", 32'(spp), 0);
    trap(1'b0, 13, 2'd3, 32'h48, 32'hABD);
    check("R5 M-mode never delegates", 32'(priv_q), 3);
    check("R9 mtval page fault", mtval, 32'hABD);
    trap(1'b1, 13, 2'd1, 32'h4C, 32'h0);
    check("R6 interrupt uses interrupt mask", 32'(priv_q), 3);
    check("R6 mcause intr 13", mcause, 32'h8000_000D);
    wr(3'd1, 32'h0000_0801);
    trap(1'b1, 5, 2'd1, 32'h50, 32'h0);
    check("R6 interrupt delegated", 32'(priv_q), 1);
    check("R4 S vectored pc", next_pc, 32'h814);
    check("R11 spp from S", 32'(spp), 1);
    check("R7 scause intr", scause, 32'h8000_0005);
    trap(1'b0, 5, 2'd0, 32'h54, 32'h77);
    check("R6 exception uses exception mask", 32'(priv_q), 3);
    check("R9 access fault tval", mtval, 32'h77);
    wr(3'd2, 32'hFFFF_FFFF);
    trap(1'b0, 40, 2'd0, 32'h58, 32'h0);
    check("R5 cause above XLEN not delegated", 32'(priv_q), 3);
    check("R7 large cause", mcause, 32'd40);
  endtask

  task automatic t_ecall;
    wr(3'd2, 32'h0);
    trap(1'b0, 8, 2'd0, 32'h60, 32'h99);
    check("R8 ecall from U", mcause, 32'd8);
    check("R9 ecall tval zero", mtval, 0);
    trap(1'b0, 8, 2'd1, 32'h64, 32'h0);
    check("R8 ecall from S", mcause, 32'd9);
    trap(1'b0, 8, 2'd3, 32'h68, 32'h0);
    check("R8 ecall from M", mcause, 32'd11);
    wr(3'd2, 32'h0000_0200);
    trap(1'b0, 8, 2'd1, 32'h6C, 32'h0);
    check("R8 remap before delegation", 32'(priv_q), 1);
    check("R8 scause 9", scause, 32'd9);
  endtask

  task automatic t_collision;
    @(negedge clk);
    trap_req = 1'b1; trap_async = 1'b0; trap_cause = CAUSE_W'(2); priv = 2'd3;
    trap_pc = 32'h70; fault_addr = 0;
    csr_we = 1'b1; csr_sel = 3'd0; csr_wdata = 32'h0000_5000;
    @(negedge clk);
    trap_req = 1'b0; csr_we = 1'b0;
    check("R13 mtvec unchanged", mtvec, 32'h2000);
    check("R13 pc uses old vector", next_pc, 32'h2000);
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tvec_filter();
    t_machine_sync();
    t_vectored();
    t_delegate();
    t_ecall();
    t_collision();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule